// File: doc/BRIEF.md
# Pointer-Indexed Dual-FIFO Host Interface

This block is the board-side end of a host link made of two byte FIFOs, one in each direction, plus two single-byte mailboxes. The host reaches it through a 3-bit address, an 8-bit data path and one-cycle read and write strobes. Offset 0 moves FIFO data: a host write pushes the outbound FIFO and a host read pops the inbound FIFO. Offset 2 is shared. A host read there returns status. A host write there loads a pointer, and the single access at offset 2 that follows reaches the register that the pointer names.

The board side pushes inbound bytes, pops outbound bytes, loads the inbound mailbox and consumes the outbound mailbox. It also arms the host interrupt, which stays silent after a hardware reset until the board arms it. The interrupt fires when a status condition is set and its mask bit is set. It also fires, with no mask able to stop it, when the master-reset flag is set.

A command register can flush all FIFO and mailbox state. It can also make the status byte show the board's own view of the link instead of the host's view.

Top module: `ptr_dual_fifo_hif`

## Requirements
- R1: A host write at offset 2 while no pointer is pending loads the pointer from data bits [2:0]. Exactly the next host read or write at offset 2 reaches the selected register. After that access, offset 2 returns to pointer and status mode.
- R2: Pointer values select these registers: 1 command, 2 interrupt mask, 3 byte-match value, 4 outbound mailbox (read and write), 5 threshold, 6 inbound mailbox (read only). Values 0 and 7 read as 0 and ignore writes. Offsets other than 0 and 2 read as 0.
- R3: In normal mapping the status byte is laid out as: bit7 master-reset flag, bit6 outbound full, bit5 inbound empty, bit4 outbound almost full, bit3 inbound almost empty, bit2 inbound mailbox full, bit1 byte match present, bit0 always 0.
- R4: The master-reset flag (status bit7) is set by hardware reset and by the flush command. A host status read clears it. It drives the interrupt whatever the mask holds.
- R5: Mask bits [6:0] line up with status bits [6:0]; mask bit7 reads as 0. When armed, the interrupt output is high exactly when the master-reset flag is set or some status bit [6:0] and its mask bit are both set.
- R6: After hardware reset the interrupt output stays low until the board pulses its arm input.
- R7: Command value 0x80 empties both FIFOs, clears both mailboxes, returns status to normal mapping and sets the master-reset flag. Command value 0x40 selects board-view mapping. Command value 0x00 restores normal mapping. The command register reads back 0x40 when board-view mapping is selected and 0x00 otherwise.
- R8: In board-view mapping the status byte is laid out as: bit7 master-reset flag, bit6 inbound full, bit5 outbound empty, bit4 inbound almost full, bit3 outbound almost empty, bit2 outbound mailbox full, bits 1:0 zero.
- R9: A host write to the outbound mailbox stores the byte and raises the board's mailbox-full output. A board consume sets the stored byte to 0 and drops the full output, so a host read-back then returns 0.
- R10: A board write to the inbound mailbox stores the byte and sets status bit2. A host read of pointer 6 returns the byte and clears bit2.
- R11: Each FIFO delivers bytes in the order they were pushed and holds DEPTH bytes. A push into a full FIFO is dropped and a pop from an empty FIFO does nothing.
- R12: Almost full is set when the free space of a FIFO is at or below the threshold register. Almost empty is set when its occupancy is at or below the threshold.
- R13: The byte-match flag is set while the inbound FIFO holds at least one byte that was equal to the byte-match register when it was pushed. It clears when the last such byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rdata | output | 8 | Host read data, valid during the read strobe |
| host_irq | output | 1 | Host interrupt |
| brd_in_push | input | 1 | Board pushes a byte into the inbound FIFO |
| brd_in_data | input | 8 | Byte pushed by the board |
| brd_in_full | output | 1 | Inbound FIFO is full |
| brd_out_pop | input | 1 | Board pops the outbound FIFO |
| brd_out_data | output | 8 | Head of the outbound FIFO |
| brd_out_empty | output | 1 | Outbound FIFO is empty |
| brd_mbin_wr | input | 1 | Board writes the inbound mailbox |
| brd_mbin_data | input | 8 | Inbound mailbox byte |
| brd_mbout_rd | input | 1 | Board consumes the outbound mailbox |
| brd_mbout_data | output | 8 | Outbound mailbox contents |
| brd_mbout_full | output | 1 | Outbound mailbox holds unconsumed data |
| brd_irq_arm | input | 1 | Board enables the host interrupt |

## Verification
The bench builds the block with DEPTH set to 16 instead of 512. At that size the bench can fill the outbound FIFO and offer a seventeenth, dropped byte in a few dozen cycles. With the threshold at 3, both almost-flag edges and both almost-empty directions can be reached with a handful of pushes. Every register behind the pointer and both status mappings are still reached, so the small depth loses nothing of the control behaviour.

// File: rtl/hif_pkg.sv
package hif_pkg;
    localparam int BYTE_W = 8;

    // Host offsets
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd2;

    // Register selected through the pointer
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CMD   = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_MATCH = 3'd3,
        SEL_OUTMB = 3'd4,
        SEL_THR   = 3'd5,
        SEL_INMB  = 3'd6,
        SEL_RSV   = 3'd7
    } sel_e;

    localparam logic [BYTE_W-1:0] CMD_FLUSH = 8'h80;
    localparam int                CMD_VIEW_BIT = 6;
endpackage

// File: rtl/hif_fifo.sv
module hif_fifo #(
    parameter int DEPTH = 512,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign push_ok = push && (f_q.cnt != CW'(DEPTH)) && !clr;
    assign pop_ok  = pop  && (f_q.cnt != '0) && !clr;

    always_comb begin
        f_d = f_q;
        if (push_ok) f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        if (pop_ok)  f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
        if (clr) f_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[f_q.wp] <= wdata;
    end

    assign rdata = mem[f_q.rp];
    assign count = f_q.cnt;
endmodule

// File: rtl/hif_status_map.sv
module hif_status_map (
    input  logic       mr,
    input  logic       board_view,
    input  logic [6:0] mask,
    input  logic       irq_on,
    input  logic       out_full,
    input  logic       in_empty,
    input  logic       out_af,
    input  logic       in_ae,
    input  logic       mbin_full,
    input  logic       match_present,
    input  logic       in_full,
    input  logic       out_empty,
    input  logic       in_af,
    input  logic       out_ae,
    input  logic       mbout_full,
    output logic [7:0] status,
    output logic       irq
);
    always_comb begin
        if (board_view)
            status = {mr, in_full, out_empty, in_af, out_ae, mbout_full, 2'b00};
        else
            status = {mr, out_full, in_empty, out_af, in_ae, mbin_full, match_present, 1'b0};
        irq = irq_on && (mr || ((status[6:0] & mask) != 7'd0));
    end
endmodule

// File: rtl/ptr_dual_fifo_hif.sv
module ptr_dual_fifo_hif
    import hif_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic              brd_in_push,
    input  logic [BYTE_W-1:0] brd_in_data,
    output logic              brd_in_full,
    input  logic              brd_out_pop,
    output logic [BYTE_W-1:0] brd_out_data,
    output logic              brd_out_empty,
    input  logic              brd_mbin_wr,
    input  logic [BYTE_W-1:0] brd_mbin_data,
    input  logic              brd_mbout_rd,
    output logic [BYTE_W-1:0] brd_mbout_data,
    output logic              brd_mbout_full,
    input  logic              brd_irq_arm
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int XW = (CW > BYTE_W) ? CW : BYTE_W;

    typedef struct packed {
        logic              armed;
        sel_e              sel;
        logic              board_view;
        logic [6:0]        mask;
        logic [BYTE_W-1:0] match;
        logic [BYTE_W-1:0] thr;
        logic [BYTE_W-1:0] mbin;
        logic              mbin_full;
        logic [BYTE_W-1:0] mbout;
        logic              mbout_full;
        logic              mr;
        logic              irq_on;
        logic [CW-1:0]     match_cnt;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]     in_cnt, out_cnt;
    logic [BYTE_W:0]   in_head;
    logic              flush;
    logic              in_push_ok, in_pop_ok, host_data_rd, host_data_wr;
    logic              in_full, in_empty, out_full, out_empty;
    logic              in_af, in_ae, out_af, out_ae;
    logic [7:0]        status;
    logic              ctrl_rd, ctrl_wr;
    logic [XW-1:0]     thr_x;

    assign host_data_rd = host_rd && (host_addr == OFS_DATA);
    assign host_data_wr = host_wr && (host_addr == OFS_DATA);
    assign ctrl_rd      = host_rd && (host_addr == OFS_CTRL);
    assign ctrl_wr      = host_wr && (host_addr == OFS_CTRL);
    assign flush        = ctrl_wr && st_q.armed && (st_q.sel == SEL_CMD)
                          && (host_wdata == CMD_FLUSH);

    assign in_full    = (in_cnt == CW'(DEPTH));
    assign in_empty   = (in_cnt == '0);
    assign out_full   = (out_cnt == CW'(DEPTH));
    assign out_empty  = (out_cnt == '0);
    assign in_push_ok = brd_in_push && !in_full && !flush;
    assign in_pop_ok  = host_data_rd && !in_empty && !flush;

    // Threshold comparisons against occupancy and free space
    assign thr_x  = XW'(st_q.thr);
    assign in_ae  = XW'(in_cnt) <= thr_x;
    assign out_ae = XW'(out_cnt) <= thr_x;
    assign in_af  = XW'(CW'(DEPTH) - in_cnt) <= thr_x;
    assign out_af = XW'(CW'(DEPTH) - out_cnt) <= thr_x;

    // Inbound entries carry a tag bit recording a match at push time
    hif_fifo #(.DEPTH(DEPTH), .W(BYTE_W + 1)) u_in_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (brd_in_push),
        .wdata ({brd_in_data == st_q.match, brd_in_data}),
        .pop   (host_data_rd),
        .rdata (in_head),
        .count (in_cnt)
    );

    hif_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_out_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (host_data_wr),
        .wdata (host_wdata),
        .pop   (brd_out_pop),
        .rdata (brd_out_data),
        .count (out_cnt)
    );

    hif_status_map u_status (
        .mr            (st_q.mr),
        .board_view    (st_q.board_view),
        .mask          (st_q.mask),
        .irq_on        (st_q.irq_on),
        .out_full      (out_full),
        .in_empty      (in_empty),
        .out_af        (out_af),
        .in_ae         (in_ae),
        .mbin_full     (st_q.mbin_full),
        .match_present (st_q.match_cnt != '0),
        .in_full       (in_full),
        .out_empty     (out_empty),
        .in_af         (in_af),
        .out_ae        (out_ae),
        .mbout_full    (st_q.mbout_full),
        .status        (status),
        .irq           (host_irq)
    );

    always_comb begin
        st_d = st_q;

        if (brd_irq_arm) st_d.irq_on = 1'b1;

        // Board side of the mailboxes; host actions below take precedence
        if (brd_mbout_rd) begin
            st_d.mbout      = '0;
            st_d.mbout_full = 1'b0;
        end

        // Match bookkeeping for the inbound FIFO
        case ({in_push_ok && (brd_in_data == st_q.match), in_pop_ok && in_head[BYTE_W]})
            2'b10:   st_d.match_cnt = st_q.match_cnt + 1'b1;
            2'b01:   st_d.match_cnt = st_q.match_cnt - 1'b1;
            default: st_d.match_cnt = st_q.match_cnt;
        endcase

        if (ctrl_rd) begin
            if (st_q.armed) begin
                st_d.armed = 1'b0;
                if (st_q.sel == SEL_INMB) st_d.mbin_full = 1'b0;
            end else begin
                st_d.mr = 1'b0;
            end
        end

        if (brd_mbin_wr) begin
            st_d.mbin      = brd_mbin_data;
            st_d.mbin_full = 1'b1;
        end

        if (ctrl_wr) begin
            if (!st_q.armed) begin
                st_d.sel   = sel_e'(host_wdata[2:0]);
                st_d.armed = 1'b1;
            end else begin
                st_d.armed = 1'b0;
                case (st_q.sel)
                    SEL_CMD: begin
                        if (host_wdata == CMD_FLUSH) begin
                            st_d.board_view = 1'b0;
                            st_d.mbin       = '0;
                            st_d.mbin_full  = 1'b0;
                            st_d.mbout      = '0;
                            st_d.mbout_full = 1'b0;
                            st_d.mr         = 1'b1;
                            st_d.match_cnt  = '0;
                        end else begin
                            st_d.board_view = host_wdata[CMD_VIEW_BIT];
                        end
                    end
                    SEL_MASK:  st_d.mask  = host_wdata[6:0];
                    SEL_MATCH: st_d.match = host_wdata;
                    SEL_OUTMB: begin
                        st_d.mbout      = host_wdata;
                        st_d.mbout_full = 1'b1;
                    end
                    SEL_THR:   st_d.thr   = host_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.mr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == OFS_DATA) begin
            host_rdata = in_head[BYTE_W-1:0];
        end else if (host_addr == OFS_CTRL) begin
            if (!st_q.armed) begin
                host_rdata = status;
            end else begin
                case (st_q.sel)
                    SEL_CMD:   host_rdata = {1'b0, st_q.board_view, 6'd0};
                    SEL_MASK:  host_rdata = {1'b0, st_q.mask};
                    SEL_MATCH: host_rdata = st_q.match;
                    SEL_OUTMB: host_rdata = st_q.mbout;
                    SEL_THR:   host_rdata = st_q.thr;
                    SEL_INMB:  host_rdata = st_q.mbin;
                    default:   host_rdata = '0;
                endcase
            end
        end
    end

    assign brd_in_full    = in_full;
    assign brd_out_empty  = out_empty;
    assign brd_mbout_data = st_q.mbout;
    assign brd_mbout_full = st_q.mbout_full;

    // Observation points for the bound checker
    logic       chk_armed, chk_mr;
    logic [2:0] chk_sel;
    assign chk_armed = st_q.armed;
    assign chk_mr    = st_q.mr;
    assign chk_sel   = st_q.sel;
endmodule

// File: rtl/hif_checker.sv
module hif_checker #(
    parameter int DEPTH = 512
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 host_addr,
    input logic                       host_rd,
    input logic                       host_wr,
    input logic                       host_irq,
    input logic                       brd_irq_arm,
    input logic                       brd_mbout_rd,
    input logic [7:0]                 brd_mbout_data,
    input logic                       brd_mbout_full,
    input logic                       chk_armed,
    input logic                       chk_mr,
    input logic [2:0]                 chk_sel,
    input logic [$clog2(DEPTH+1)-1:0] in_cnt,
    input logic [$clog2(DEPTH+1)-1:0] out_cnt
);
    logic arm_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           arm_seen <= 1'b0;
        else if (brd_irq_arm) arm_seen <= 1'b1;
    end

    assert_ptr_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd2 && !chk_armed) |=> chk_armed);

    assert_ptr_return_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && host_addr == 3'd2 && chk_armed) |=> !chk_armed);

    assert_mr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 3'd2 && !chk_armed) |=> !chk_mr);

    assert_mr_unmaskable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_seen && $past(brd_irq_arm || arm_seen) && chk_mr) |-> host_irq);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_seen |-> !host_irq);

    assert_mbox_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_mbout_rd && !(host_wr && host_addr == 3'd2 && chk_armed && chk_sel == 3'd4))
        |=> (brd_mbout_data == 8'd0 && !brd_mbout_full));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt <= ($clog2(DEPTH+1))'(DEPTH)) && (out_cnt <= ($clog2(DEPTH+1))'(DEPTH)));
endmodule

bind ptr_dual_fifo_hif hif_checker #(.DEPTH(DEPTH)) u_hif_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_addr      (host_addr),
    .host_rd        (host_rd),
    .host_wr        (host_wr),
    .host_irq       (host_irq),
    .brd_irq_arm    (brd_irq_arm),
    .brd_mbout_rd   (brd_mbout_rd),
    .brd_mbout_data (brd_mbout_data),
    .brd_mbout_full (brd_mbout_full),
    .chk_armed      (chk_armed),
    .chk_mr         (chk_mr),
    .chk_sel        (chk_sel),
    .in_cnt         (in_cnt),
    .out_cnt        (out_cnt)
);

// File: tb/ptr_dual_fifo_hif_tb.sv
module ptr_dual_fifo_hif_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       brd_in_push = 1'b0;
    logic [7:0] brd_in_data = '0;
    logic       brd_in_full;
    logic       brd_out_pop = 1'b0;
    logic [7:0] brd_out_data;
    logic       brd_out_empty;
    logic       brd_mbin_wr = 1'b0;
    logic [7:0] brd_mbin_data = '0;
    logic       brd_mbout_rd = 1'b0;
    logic [7:0] brd_mbout_data;
    logic       brd_mbout_full;
    logic       brd_irq_arm = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ptr_dual_fifo_hif #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    task automatic ptr_wr(input logic [2:0] s, input logic [7:0] d);
        hwr(3'd2, {5'd0, s});
        hwr(3'd2, d);
    endtask

    task automatic ptr_rd(input logic [2:0] s, output logic [7:0] d);
        hwr(3'd2, {5'd0, s});
        hrd(3'd2, d);
    endtask

    task automatic bpush(input logic [7:0] d);
        @(negedge clk);
        brd_in_data = d; brd_in_push = 1'b1;
        @(posedge clk); #1 brd_in_push = 1'b0;
    endtask

    task automatic bpop(output logic [7:0] d);
        @(negedge clk);
        d = brd_out_data; brd_out_pop = 1'b1;
        @(posedge clk); #1 brd_out_pop = 1'b0;
    endtask

    task automatic pulse_mbin(input logic [7:0] d);
        @(negedge clk);
        brd_mbin_data = d; brd_mbin_wr = 1'b1;
        @(posedge clk); #1 brd_mbin_wr = 1'b0;
    endtask

    task automatic pulse_mbout_rd();
        @(negedge clk); brd_mbout_rd = 1'b1;
        @(posedge clk); #1 brd_mbout_rd = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); brd_irq_arm = 1'b1;
        @(posedge clk); #1 brd_irq_arm = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        check("R6 irq low after reset", host_irq, 0);
        hrd(3'd2, v);
        check("R3 R4 status after reset", v, 8'hA8);
        hrd(3'd2, v);
        check("R4 master-reset cleared by read", v, 8'h28);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        ptr_wr(3'd5, 8'h03);
        hrd(3'd2, v);
        check("R1 offset back in status mode", v, 8'h28);
        ptr_rd(3'd5, v);
        check("R2 threshold read-back", v, 8'h03);
        ptr_wr(3'd7, 8'h55);
        ptr_rd(3'd7, v);
        check("R2 reserved select reads 0", v, 8'h00);
        hrd(3'd5, v);
        check("R2 unused offset reads 0", v, 8'h00);
        ptr_rd(3'd5, v);
        check("R2 threshold kept after reserved write", v, 8'h03);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        for (int i = 0; i <= DEPTH; i++) hwr(3'd0, 8'hA0 + 8'(i));
        hrd(3'd2, v);
        check("R3 R12 status with outbound full", v, 8'h78);
        for (int i = 0; i < DEPTH; i++) begin
            bpop(v);
            check("R11 outbound order", v, 8'hA0 + i);
        end
        @(negedge clk);
        check("R11 overfill byte dropped", brd_out_empty, 1);
        bpush(8'h11); bpush(8'h12); bpush(8'h13);
        hrd(3'd2, v);
        check("R12 almost empty at threshold", v, 8'h08);
        bpush(8'h14);
        hrd(3'd2, v);
        check("R12 almost empty above threshold", v, 8'h00);
        for (int i = 0; i < 4; i++) begin
            hrd(3'd0, v);
            check("R11 inbound order", v, 8'h11 + i);
        end
        hrd(3'd0, v);
        hrd(3'd2, v);
        check("R11 pop of empty inbound ignored", v, 8'h28);
    endtask

    task automatic t_match();
        logic [7:0] v;
        ptr_wr(3'd3, 8'h5A);
        bpush(8'h01); bpush(8'h5A); bpush(8'h02);
        hrd(3'd2, v);
        check("R13 match flag set", v, 8'h0A);
        hrd(3'd0, v);
        hrd(3'd2, v);
        check("R13 match flag held", v, 8'h0A);
        hrd(3'd0, v);
        check("R13 matched byte delivered", v, 8'h5A);
        hrd(3'd2, v);
        check("R13 match flag cleared on pop", v, 8'h08);
        hrd(3'd0, v);
        ptr_wr(3'd3, 8'h00);
    endtask

    task automatic t_mailbox();
        logic [7:0] v;
        pulse_mbin(8'h77);
        hrd(3'd2, v);
        check("R10 inbound mailbox status bit", v, 8'h2C);
        ptr_rd(3'd6, v);
        check("R10 inbound mailbox data", v, 8'h77);
        hrd(3'd2, v);
        check("R10 inbound mailbox cleared", v, 8'h28);
        ptr_wr(3'd4, 8'hC4);
        @(negedge clk);
        check("R9 outbound mailbox full", brd_mbout_full, 1);
        check("R9 outbound mailbox data", brd_mbout_data, 8'hC4);
        ptr_rd(3'd4, v);
        check("R9 outbound mailbox read-back", v, 8'hC4);
        pulse_mbout_rd();
        ptr_rd(3'd4, v);
        check("R9 consumed mailbox reads 0", v, 8'h00);
        check("R9 mailbox full dropped", brd_mbout_full, 0);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        ptr_wr(3'd2, 8'h20);
        @(negedge clk);
        check("R6 irq low before arm", host_irq, 0);
        pulse_arm();
        @(negedge clk);
        check("R5 irq on unmasked inbound empty", host_irq, 1);
        ptr_wr(3'd2, 8'h84);
        @(negedge clk);
        check("R5 irq low when masked", host_irq, 0);
        ptr_rd(3'd2, v);
        check("R5 mask read-back bit7 zero", v, 8'h04);
        pulse_mbin(8'h3C);
        @(negedge clk);
        check("R5 irq on inbound mailbox", host_irq, 1);
        ptr_rd(3'd6, v);
        @(negedge clk);
        check("R5 irq drops after mailbox read", host_irq, 0);
        ptr_wr(3'd2, 8'h00);
        ptr_wr(3'd1, 8'h80);
        @(negedge clk);
        check("R4 master-reset irq unmaskable", host_irq, 1);
        hrd(3'd2, v);
        check("R4 status after flush", v, 8'hA8);
        @(negedge clk);
        check("R4 irq drops after status read", host_irq, 0);
    endtask

    task automatic t_cmd();
        logic [7:0] v;
        hwr(3'd0, 8'h31); hwr(3'd0, 8'h32);
        bpush(8'h09);
        pulse_mbin(8'h55);
        ptr_wr(3'd4, 8'h66);
        ptr_wr(3'd1, 8'h40);
        ptr_wr(3'd1, 8'h80);
        @(negedge clk);
        check("R7 flush empties outbound", brd_out_empty, 1);
        check("R7 flush clears outbound mailbox", brd_mbout_full, 0);
        hrd(3'd2, v);
        check("R7 flush status in normal view", v, 8'hA8);
        ptr_rd(3'd1, v);
        check("R7 command read-back after flush", v, 8'h00);
        ptr_wr(3'd1, 8'h40);
        ptr_rd(3'd1, v);
        check("R7 command read-back board view", v, 8'h40);
        hwr(3'd0, 8'h41); hwr(3'd0, 8'h42);
        hrd(3'd2, v);
        check("R8 board view outbound almost empty", v, 8'h08);
        ptr_wr(3'd4, 8'h66);
        hrd(3'd2, v);
        check("R8 board view outbound mailbox", v, 8'h0C);
        ptr_wr(3'd1, 8'h00);
        hrd(3'd2, v);
        check("R7 normal view restored", v, 8'h28);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_fifo();
        t_match();
        t_mailbox();
        t_irq();
        t_cmd();
        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule